// File: doc/BRIEF.md
# Flash Write-Protection Controller

This block guards a 512 KB serial flash made of eight 64 KB blocks. It holds the protection fields of the flash status register: a top/bottom selector, a lock bit and a three-bit protection code. For every program, sector-erase or chip-erase request it returns a one-cycle grant or deny answer. The command parser presents a status-register write with its data byte, the level of the active-low write-protect pin, and the requests with their byte address. It acts on the answer before it starts any array operation.

The protection code selects a region that grows in eighths of the memory. The region is anchored at the top of memory when the selector is 0 and at the bottom when it is 1. The steps are one, two, four, six and seven blocks, and the two highest codes cover the whole array. The lock bit freezes all protection fields, but only while the pin is held low. A chip erase is allowed only when the protection code is zero.

Top module: `flash_wp_ctrl`

## Requirements
- R1: Power-on reset (rst_n low) clears tb_o, bpl_o and bp_o to 0 and holds resp_valid low.
- R2: A pulse on sr_wr_en loads bp_o from sr_wr_data[4:2] (bit 2 is the least significant bit), tb_o from bit 5 and bpl_o from bit 7, visible one cycle later. The load happens when wp_n is 1 or bpl_o is 0. Bits 0, 1 and 6 are ignored. Without sr_wr_en the fields keep their values.
- R3: While wp_n is 0 and bpl_o is 1, a status write leaves tb_o, bpl_o and bp_o unchanged, and requests are still judged against the unchanged fields.
- R4: While wp_n is 1, bpl_o has no effect: a status write is accepted whatever its value, including a write that clears it.
- R5: Code bp 000 protects no block, and codes 110 and 111 protect all eight blocks. In all three cases tb has no effect.
- R6: With tb=0, codes 001/010/011/100/101 protect blocks 7, 6-7, 4-7, 2-7 and 1-7.
- R7: With tb=1, codes 001/010/011/100/101 protect blocks 0, 0-1, 0-3, 0-5 and 0-6.
- R8: A program (req_kind 00) or sector erase (req_kind 01) is granted if and only if the 64 KB block holding its address, req_addr[18:16], is unprotected. A sector erase is judged on its 4 KB-aligned sector, so address bits 11:0 have no effect.
- R9: A chip erase (req_kind 10) is granted only when bp is 000, whatever tb and bpl are.
- R10: resp_valid is 1 exactly one cycle after each cycle with req_valid high and 0 otherwise. The answer uses the fields held in the request cycle, so a status write in that same cycle does not affect it. Request kind 11 is always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| sr_wr_en | input | 1 | Status-register write strobe |
| sr_wr_data | input | 8 | Status-register data byte |
| wp_n | input | 1 | Write-protect pin level, active low |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| req_addr | input | 19 | Byte address of the request |
| tb_o | output | 1 | Region anchor: 0 top, 1 bottom |
| bpl_o | output | 1 | Lock bit |
| bp_o | output | 3 | Protection code |
| resp_valid | output | 1 | Answer valid, one cycle after the request |
| resp_grant | output | 1 | 1 grants, 0 denies the request |

## Verification
On every cycle the assertions check the following: locked fields stay frozen under a write with the pin low, an accepted write lands at its bit positions, the fields hold when there is no write, and the answer follows the strobe by one cycle. They also check that chip erase is refused with a nonzero code, and that the all-or-nothing codes give an empty or full block mask. Only the bench scenarios can show that the full region table is right. They sweep all sixteen selector/code pairs against an address in each block, test sector alignment at block edges, cover all four pin/lock combinations, and check that a request issued in the same cycle as a status write is judged on the old fields.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    typedef enum logic [1:0] {
        REQ_PROGRAM = 2'b00,
        REQ_SECTOR  = 2'b01,
        REQ_CHIP    = 2'b10,
        REQ_RSVD    = 2'b11
    } req_kind_e;

    typedef struct packed {
        logic       tb;
        logic       bpl;
        logic [2:0] bp;
    } prot_bits_t;

    localparam int SR_DATA_W  = 8;
    localparam int SRB_BP_LSB = 2;
    localparam int SRB_TB     = 5;
    localparam int SRB_BPL    = 7;
    localparam int BP_W       = 3;

endpackage

// File: rtl/wp_status_reg.sv
module wp_status_reg
    import flash_wp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SR_DATA_W-1:0] wr_data,
    input  logic                 wp_n,
    output prot_bits_t           prot_o
);

    typedef struct packed {
        prot_bits_t bits;
    } sr_state_t;

    sr_state_t st_d, st_q;
    logic      wr_allowed;

    logic unused_sr_bits;
    assign unused_sr_bits = ^{wr_data[1:0], wr_data[6]};

    always_comb begin
        st_d       = st_q;
        wr_allowed = wp_n | ~st_q.bits.bpl;
        if (wr_en && wr_allowed) begin
            st_d.bits.bp  = wr_data[SRB_BP_LSB +: BP_W];
            st_d.bits.tb  = wr_data[SRB_TB];
            st_d.bits.bpl = wr_data[SRB_BPL];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prot_o = st_q.bits;

    // R3: pin low with lock set freezes every protection field
    assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wp_n && prot_o.bpl) |=> $stable(prot_o));

    // R2 and R4: an accepted write lands at its fixed bit positions
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wp_n || !prot_o.bpl)) |=>
        (prot_o.bp == $past(wr_data[SRB_BP_LSB +: BP_W]) &&
         prot_o.tb == $past(wr_data[SRB_TB]) &&
         prot_o.bpl == $past(wr_data[SRB_BPL])));

    // R2: no write strobe, no change
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(prot_o));

endmodule

// File: rtl/wp_range_decode.sv
module wp_range_decode
    import flash_wp_pkg::*;
#(
    parameter int NUM_BLOCKS = 8
) (
    input  prot_bits_t            prot,
    output logic [NUM_BLOCKS-1:0] blk_mask
);

    localparam int CNT_W = $clog2(NUM_BLOCKS + 1);
    localparam logic [CNT_W-1:0] SPAN_ALL  = CNT_W'(NUM_BLOCKS);
    localparam logic [CNT_W-1:0] SPAN_1_8  = CNT_W'(NUM_BLOCKS / 8);
    localparam logic [CNT_W-1:0] SPAN_1_4  = CNT_W'(NUM_BLOCKS / 4);
    localparam logic [CNT_W-1:0] SPAN_1_2  = CNT_W'(NUM_BLOCKS / 2);
    localparam logic [CNT_W-1:0] SPAN_6_8  = CNT_W'(NUM_BLOCKS - NUM_BLOCKS / 4);
    localparam logic [CNT_W-1:0] SPAN_7_8  = CNT_W'(NUM_BLOCKS - NUM_BLOCKS / 8);

    logic [CNT_W-1:0] span;
    logic [CNT_W-1:0] top_floor;

    logic unused_lock;
    assign unused_lock = prot.bpl;

    always_comb begin
        unique case (prot.bp)
            3'b000:  span = '0;
            3'b001:  span = SPAN_1_8;
            3'b010:  span = SPAN_1_4;
            3'b011:  span = SPAN_1_2;
            3'b100:  span = SPAN_6_8;
            3'b101:  span = SPAN_7_8;
            default: span = SPAN_ALL;
        endcase
        top_floor = SPAN_ALL - span;
    end

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
        localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
        assign blk_mask[i] = prot.tb ? (IDX < span) : (IDX >= top_floor);
    end

endmodule

// File: rtl/wp_request_judge.sv
module wp_request_judge
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int NUM_BLOCKS = 8,
    parameter int SECTOR_AW  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_kind,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [NUM_BLOCKS-1:0] blk_mask,
    input  logic                  bp_clear,
    output logic                  resp_valid,
    output logic                  resp_grant
);

    localparam int BLK_W = $clog2(NUM_BLOCKS);
    localparam int SEC_W = ADDR_W - SECTOR_AW;

    typedef struct packed {
        logic valid;
        logic grant;
    } resp_t;

    resp_t            rs_d, rs_q;
    logic [SEC_W-1:0] sector_idx;
    logic [BLK_W-1:0] blk_idx;
    logic             blk_locked;

    assign sector_idx = req_addr[ADDR_W-1:SECTOR_AW];
    assign blk_idx    = sector_idx[SEC_W-1 -: BLK_W];
    assign blk_locked = blk_mask[blk_idx];

    logic unused_addr_bits;
    assign unused_addr_bits = ^{req_addr[SECTOR_AW-1:0], sector_idx[SEC_W-BLK_W-1:0]};

    always_comb begin
        rs_d.valid = req_valid;
        rs_d.grant = 1'b0;
        if (req_valid) begin
            unique case (req_kind_e'(req_kind))
                REQ_PROGRAM: rs_d.grant = ~blk_locked;
                REQ_SECTOR:  rs_d.grant = ~blk_locked;
                REQ_CHIP:    rs_d.grant = bp_clear;
                default:     rs_d.grant = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign resp_valid = rs_q.valid;
    assign resp_grant = rs_q.grant;

    // R10: answer follows the strobe by exactly one cycle
    assert_resp_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    // R9: chip erase refused with any nonzero code
    assert_chip_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == REQ_CHIP && !bp_clear) |=> (resp_valid && !resp_grant));

    // R8: request into a protected block refused
    assert_blk_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == REQ_PROGRAM || req_kind == REQ_SECTOR) && blk_locked)
        |=> !resp_grant);

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int NUM_BLOCKS = 8,
    parameter int SECTOR_AW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_wr_en,
    input  logic [7:0]        sr_wr_data,
    input  logic              wp_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              tb_o,
    output logic              bpl_o,
    output logic [2:0]        bp_o,
    output logic              resp_valid,
    output logic              resp_grant
);

    prot_bits_t            prot_q;
    logic [NUM_BLOCKS-1:0] blk_mask;
    logic                  bp_clear;

    wp_status_reg u_sr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sr_wr_en),
        .wr_data (sr_wr_data),
        .wp_n    (wp_n),
        .prot_o  (prot_q)
    );

    wp_range_decode #(
        .NUM_BLOCKS (NUM_BLOCKS)
    ) u_dec (
        .prot     (prot_q),
        .blk_mask (blk_mask)
    );

    assign bp_clear = (prot_q.bp == '0);

    wp_request_judge #(
        .ADDR_W     (ADDR_W),
        .NUM_BLOCKS (NUM_BLOCKS),
        .SECTOR_AW  (SECTOR_AW)
    ) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_addr   (req_addr),
        .blk_mask   (blk_mask),
        .bp_clear   (bp_clear),
        .resp_valid (resp_valid),
        .resp_grant (resp_grant)
    );

    assign tb_o  = prot_q.tb;
    assign bpl_o = prot_q.bpl;
    assign bp_o  = prot_q.bp;

    // R5: the no-protection and full-protection codes ignore tb
    assert_code_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q.bp == 3'b000) |-> (blk_mask == '0));
    assert_code_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q.bp[2] && prot_q.bp[1]) |-> (&blk_mask));

endmodule

// File: tb/sim_flash_wp_ctrl.sv
`timescale 1ns/1ps
module sim_flash_wp_ctrl;

    localparam real CLK_PERIOD = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sr_wr_en = 1'b0;
    logic [7:0]  sr_wr_data = '0;
    logic        wp_n = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [18:0] req_addr = '0;
    logic        tb_o, bpl_o, resp_valid, resp_grant;
    logic [2:0]  bp_o;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    flash_wp_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .wp_n(wp_n), .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .tb_o(tb_o), .bpl_o(bpl_o), .bp_o(bp_o),
        .resp_valid(resp_valid), .resp_grant(resp_grant)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    exp_q[$];
    string tag_q[$];
    logic  m_tb = 0, m_bpl = 0;
    logic [2:0] m_bp = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // independent table of protected block ranges
    function automatic bit blk_prot(input logic tb, input logic [2:0] bp, input int blk);
        int lo, hi;
        if (bp == 3'b000) return 0;
        if (bp == 3'b110 || bp == 3'b111) return 1;
        case ({tb, bp})
            4'b0001: begin lo = 7; hi = 7; end
            4'b0010: begin lo = 6; hi = 7; end
            4'b0011: begin lo = 4; hi = 7; end
            4'b0100: begin lo = 2; hi = 7; end
            4'b0101: begin lo = 1; hi = 7; end
            4'b1001: begin lo = 0; hi = 0; end
            4'b1010: begin lo = 0; hi = 1; end
            4'b1011: begin lo = 0; hi = 3; end
            4'b1100: begin lo = 0; hi = 5; end
            default: begin lo = 0; hi = 6; end
        endcase
        return (blk >= lo) && (blk <= hi);
    endfunction

    task automatic check_status(input string tag);
        check({tb_o, bpl_o, bp_o} == {m_tb, m_bpl, m_bp}, tag, "status tb/bpl/bp",
              int'({tb_o, bpl_o, bp_o}), int'({m_tb, m_bpl, m_bp}));
    endtask

    task automatic sr_write(input logic [7:0] data, input string tag);
        @(negedge clk);
        sr_wr_en = 1'b1;
        sr_wr_data = data;
        if (wp_n || !m_bpl) begin
            m_bp = data[4:2];
            m_tb = data[5];
            m_bpl = data[7];
        end
        @(negedge clk);
        sr_wr_en = 1'b0;
        check_status(tag);
    endtask

    task automatic do_req(input logic [1:0] kind, input logic [18:0] addr,
                          input bit exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind = kind;
        req_addr = addr;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done && resp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "response without request", 1, 0);
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(resp_grant == e, t, "grant", int'(resp_grant), int'(e));
            end
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_status("R1");
        check(resp_valid == 1'b0, "R1", "resp_valid after reset", int'(resp_valid), 0);

        // sweep all selector/code pairs; bits 0,1,6 carry junk (R2)
        wp_n = 1'b1;
        for (int code = 0; code < 16; code++) begin
            logic [3:0] c;
            string      rtag;
            c = code[3:0];
            sr_write({1'b0, 1'b1, c, 2'b11}, "R2");
            if (c[2:0] == 3'b000 || c[2:0] >= 3'b110) rtag = "R5";
            else rtag = c[3] ? "R7" : "R6";
            for (int blk = 0; blk < 8; blk++) begin
                bit p;
                p = blk_prot(c[3], c[2:0], blk);
                do_req(2'b00, 19'(blk * 65536 + 'h1234), !p, rtag);
                do_req(2'b01, 19'(blk * 65536 + 'hFFFF), !p, "R8");
                do_req(2'b01, 19'(blk * 65536), !p, "R8");
            end
            do_req(2'b10, 19'h0, c[2:0] == 3'b000, "R9");
            do_req(2'b11, 19'h0, 1'b0, "R10");
        end

        // pin high: lock bit set but ignored (R4)
        sr_write(8'h8C, "R4");
        sr_write(8'h90, "R4");
        do_req(2'b00, 19'h7_0000, 1'b0, "R6");
        // pin low and locked: writes frozen (R3)
        @(negedge clk); wp_n = 1'b0;
        sr_write(8'h00, "R3");
        sr_write(8'h24, "R3");
        do_req(2'b00, 19'h2_0000, 1'b0, "R3");
        do_req(2'b00, 19'h1_0000, 1'b1, "R3");
        // pin high again: clearing the lock is allowed (R4)
        @(negedge clk); wp_n = 1'b1;
        sr_write(8'h24, "R4");
        // pin low, lock clear: writes accepted (R2)
        @(negedge clk); wp_n = 1'b0;
        sr_write(8'h0C, "R2");
        sr_write(8'h98, "R2");
        sr_write(8'h00, "R3");
        do_req(2'b10, 19'h0, 1'b0, "R9");

        // request and status write in one cycle: judged on old code (R10)
        @(negedge clk); wp_n = 1'b1;
        @(negedge clk);
        sr_wr_en = 1'b1; sr_wr_data = 8'h00;
        req_valid = 1'b1; req_kind = 2'b10; req_addr = '0;
        exp_q.push_back(1'b0); tag_q.push_back("R10");
        m_bp = 3'b000; m_tb = 1'b0; m_bpl = 1'b0;
        @(negedge clk);
        sr_wr_en = 1'b0; req_valid = 1'b0;
        check_status("R10");
        do_req(2'b10, 19'h0, 1'b1, "R9");
        do_req(2'b00, 19'h7_FFFF, 1'b1, "R5");

        // reset mid-run clears everything (R1)
        sr_write(8'hBC, "R2");
        @(negedge clk); rst_n = 1'b0;
        m_tb = 0; m_bpl = 0; m_bp = 0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check_status("R1");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10", "responses outstanding", exp_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end

endmodule